// File: doc/BRIEF.md
# Word Sync Sequence Generator

This block is one transmit lane in front of a serializer. It turns a byte stream into 10-bit 8b/10b code groups. On request it replaces that traffic with a fixed train of sixteen comma characters (K28.5). A receiver uses the train as a single mark to align several lanes against each other. In two fixed places inside the train the running-disparity alternation is broken on purpose, which makes the pattern unique.

Each character time the block samples a sync request, a control/data flag and a data byte. One clock later it presents the code group, the running disparity and a status bit that marks sync characters. A request starts the train. The block then ignores its inputs until the train is finished. If the request is still high at that point, a new train follows with no gap. Otherwise encoded traffic resumes from the running disparity that the last comma left behind.

Top module: `wsync_gen`

## Requirements
- R1: While reset is high and after it is released, before the first character edge, `code_out` is 0, `rd_pos` is 0 (negative running disparity) and `sync_active` is 0.
- R2: When no train is running and `sync_req` is low, a byte with `ctrl_flag` low is emitted one clock later as its 8b/10b data code group. The group is selected by the current running disparity. `code_out[0]` carries bit a (sent first), `code_out[5:0]` = {i,e,d,c,b,a} and `code_out[9:6]` = {j,h,g,f}.
- R3: With `ctrl_flag` high, the bytes K28.0 to K28.7 (low five bits 28), K23.7 (0xF7), K27.7 (0xFB), K29.7 (0xFD) and K30.7 (0xFE) are emitted as control code groups. Any other byte is emitted as the data code group for that byte.
- R4: Outside a train, `rd_pos` toggles after each unbalanced code group (weight 4 or 6) and holds after each balanced one (weight 5).
- R5: A high `sync_req` sampled while no train is running, or while the last character of a train is on the output, makes the next output a comma with `sync_active` high. `ctrl_flag` and `data_in` in that cycle have no effect.
- R6: Every character of a train is one of two comma forms: 0x17C (leaves `rd_pos` = 1) or 0x283 (leaves `rd_pos` = 0).
- R7: If `rd_pos` was 0 when the train started, the train's resulting polarities are + + - - + - + - + - + - + - + -. If it was 1, they are - - + + - + - + - + - + - + - +.
- R8: For the 15 character times after the starting one, `sync_req`, `ctrl_flag` and `data_in` have no effect on the output.
- R9: In the cycle after the 16th comma, the output is the normal encoding of the new input. That encoding starts from the disparity of the 16th comma: negative for the first variant, positive for the second.
- R10: A request held high produces trains back to back with no character between them, and each train picks its variant from the disparity at its own start.
- R11: `sync_active` is high for exactly the 16 character times of each train and low for all other characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_req | input | 1 | Request to start an alignment train |
| ctrl_flag | input | 1 | High: byte is a control character |
| data_in | input | 8 | Byte to encode, {HGF,EDCBA} |
| code_out | output | 10 | Code group, bit 0 sent first |
| rd_pos | output | 1 | Running disparity after `code_out`, 1 = positive |
| sync_active | output | 1 | High while `code_out` is a train character |

## Verification
The hardest situation to reach is the second train variant. It needs positive running disparity at the exact edge where the request is sampled, and a reset always leaves the lane negative. The stimulus sends random data bytes while its own disparity model reports negative, then raises the request. Back-to-back trains and requests that arrive during the last comma are driven by holding the request high across train boundaries. During lockouts the request, flag and byte are filled with random values.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

   // Code group bit order: {j,h,g,f,i,e,d,c,b,a}, bit 0 leaves the lane first.
   typedef logic [9:0] code_t;

   // Comma byte: y = 5, x = 28.
   localparam logic [7:0] COMMA_BYTE = 8'hBC;

   // The two comma encodings, named by the disparity they leave behind.
   localparam code_t COMMA_LEAVES_POS = 10'h17C;
   localparam code_t COMMA_LEAVES_NEG = 10'h283;

endpackage

// File: rtl/wsg_enc_6b.sv
module wsg_enc_6b (
   input  logic [4:0] sym5,
   input  logic       is_k28,
   input  logic       rd_in,
   output logic [5:0] grp6,
   output logic       rd_mid
);

   logic [5:0] neg_form;   // written a,b,c,d,e,i from left to right
   logic [5:0] base;       // base[0] = a
   logic       unbal;
   logic       twin;

   always_comb begin
      unique case (sym5)
         5'd0 : neg_form = 6'b100111;
         5'd1 : neg_form = 6'b011101;
         5'd2 : neg_form = 6'b101101;
         5'd3 : neg_form = 6'b110001;
         5'd4 : neg_form = 6'b110101;
         5'd5 : neg_form = 6'b101001;
         5'd6 : neg_form = 6'b011001;
         5'd7 : neg_form = 6'b111000;
         5'd8 : neg_form = 6'b111001;
         5'd9 : neg_form = 6'b100101;
         5'd10: neg_form = 6'b010101;
         5'd11: neg_form = 6'b110100;
         5'd12: neg_form = 6'b001101;
         5'd13: neg_form = 6'b101100;
         5'd14: neg_form = 6'b011100;
         5'd15: neg_form = 6'b010111;
         5'd16: neg_form = 6'b011011;
         5'd17: neg_form = 6'b100011;
         5'd18: neg_form = 6'b010011;
         5'd19: neg_form = 6'b110010;
         5'd20: neg_form = 6'b001011;
         5'd21: neg_form = 6'b101010;
         5'd22: neg_form = 6'b011010;
         5'd23: neg_form = 6'b111010;
         5'd24: neg_form = 6'b110011;
         5'd25: neg_form = 6'b100110;
         5'd26: neg_form = 6'b010110;
         5'd27: neg_form = 6'b110110;
         5'd28: neg_form = 6'b001110;
         5'd29: neg_form = 6'b101110;
         5'd30: neg_form = 6'b011110;
         default: neg_form = 6'b101011;
      endcase
      if (is_k28) begin
         neg_form = 6'b001111;
      end
      for (int n = 0; n < 6; n++) begin
         base[n] = neg_form[5-n];
      end
      unbal = ($countones(base) != 3);
      // the one balanced group that still has two forms
      twin  = (sym5 == 5'd7) && !is_k28;
      grp6   = (rd_in && (unbal || twin)) ? ~base : base;
      rd_mid = unbal ? ~rd_in : rd_in;
   end

endmodule

// File: rtl/wsg_enc_4b.sv
module wsg_enc_4b (
   input  logic [2:0] sym3,
   input  logic [4:0] sym5,
   input  logic       k_valid,
   input  logic       is_k28,
   input  logic       rd_mid,
   output logic [3:0] grp4,
   output logic       rd_out
);

   logic       use_alt;
   logic [3:0] neg_form;   // written f,g,h,j from left to right
   logic [3:0] base;       // base[0] = f
   logic       unbal;
   logic       flip;
   logic       k_swap;

   always_comb begin
      use_alt = k_valid
             || (!rd_mid && (sym5 inside {5'd17, 5'd18, 5'd20}))
             || ( rd_mid && (sym5 inside {5'd11, 5'd13, 5'd14}));
      unique case (sym3)
         3'd0: neg_form = 4'b1011;
         3'd1: neg_form = 4'b1001;
         3'd2: neg_form = 4'b0101;
         3'd3: neg_form = 4'b1100;
         3'd4: neg_form = 4'b1101;
         3'd5: neg_form = 4'b1010;
         3'd6: neg_form = 4'b0110;
         default: neg_form = use_alt ? 4'b0111 : 4'b1110;
      endcase
      for (int n = 0; n < 4; n++) begin
         base[n] = neg_form[3-n];
      end
      unbal  = ($countones(base) != 2);
      flip   = rd_mid && (unbal || (sym3 == 3'd3));
      // after a K28 prefix the balanced tails take their mirror form
      k_swap = is_k28 && !rd_mid && (sym3 inside {3'd1, 3'd2, 3'd5, 3'd6});
      grp4   = (flip || k_swap) ? ~base : base;
      rd_out = unbal ? ~rd_mid : rd_mid;
   end

endmodule

// File: rtl/wsg_seq_ctrl.sv
module wsg_seq_ctrl #(
   parameter int                 SEQ_LEN  = 16,
   parameter logic [SEQ_LEN-1:0] REV_MASK = {{(SEQ_LEN-4){1'b0}}, 4'b1010}
) (
   input  logic clk,
   input  logic rst,
   input  logic sync_req,
   input  logic rd_now,
   output logic emit_sync,
   output logic emit_pol,
   output logic active_q
);

   localparam int                CNT_W = $clog2(SEQ_LEN);
   localparam logic [CNT_W-1:0]  LAST  = CNT_W'(SEQ_LEN - 1);

   // Resulting polarity of each character for a train started at negative disparity.
   function automatic logic [SEQ_LEN-1:0] build_pol();
      logic [SEQ_LEN-1:0] p;
      p[0] = 1'b1;
      for (int n = 1; n < SEQ_LEN; n++) begin
         p[n] = REV_MASK[n] ? p[n-1] : ~p[n-1];
      end
      return p;
   endfunction

   localparam logic [SEQ_LEN-1:0] POL_A = build_pol();

   if (SEQ_LEN < 4) begin : g_bad_len
      $error("wsg_seq_ctrl: SEQ_LEN must be at least 4");
   end
   if (REV_MASK[0]) begin : g_bad_mask
      $error("wsg_seq_ctrl: the first character cannot repeat a polarity");
   end

   logic [CNT_W-1:0] pos_q, pos_nx;
   logic             var_q, var_nx;
   logic             carry_on, start;

   always_comb begin
      carry_on  = active_q && (pos_q != LAST);
      start     = !carry_on && sync_req;
      emit_sync = carry_on || start;
      pos_nx    = carry_on ? pos_q + CNT_W'(1) : '0;
      var_nx    = start ? rd_now : var_q;
      emit_pol  = POL_A[pos_nx] ^ var_nx;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         pos_q    <= '0;
         var_q    <= 1'b0;
      end else begin
         active_q <= emit_sync;
         pos_q    <= pos_nx;
         var_q    <= var_nx;
      end
   end

   AST_TRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (active_q && pos_q != LAST) |=> active_q) else $error("train cut short"); // R8

   AST_TRAIN_LENGTH: assert property (@(posedge clk) disable iff (rst)
      (active_q && pos_q == LAST && !sync_req) |=> !active_q) else $error("train overran"); // R11

endmodule

// File: rtl/wsync_gen.sv
module wsync_gen #(
   parameter int                 SEQ_LEN  = 16,
   parameter logic [SEQ_LEN-1:0] REV_MASK = {{(SEQ_LEN-4){1'b0}}, 4'b1010}
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       sync_req,
   input  logic       ctrl_flag,
   input  logic [7:0] data_in,
   output logic [9:0] code_out,
   output logic       rd_pos,
   output logic       sync_active
);
   import wsg_pkg::*;

   logic       emit_sync, emit_pol;
   logic [7:0] enc_byte;
   logic       enc_k, enc_rd;
   logic       k_valid, is_k28;
   logic [5:0] grp6;
   logic [3:0] grp4;
   logic       rd_mid, rd_next;
   code_t      code_q;
   logic       rd_q;

   wsg_seq_ctrl #(
      .SEQ_LEN  (SEQ_LEN),
      .REV_MASK (REV_MASK)
   ) i_seq (
      .clk       (clk),
      .rst       (rst),
      .sync_req  (sync_req),
      .rd_now    (rd_q),
      .emit_sync (emit_sync),
      .emit_pol  (emit_pol),
      .active_q  (sync_active)
   );

   always_comb begin
      enc_byte = emit_sync ? COMMA_BYTE : data_in;
      enc_k    = emit_sync || ctrl_flag;
      // a train character is encoded from the disparity opposite its target polarity
      enc_rd   = emit_sync ? ~emit_pol : rd_q;
      k_valid  = enc_k && ((enc_byte[4:0] == 5'd28)
               || ((enc_byte[7:5] == 3'd7)
                   && (enc_byte[4:0] inside {5'd23, 5'd27, 5'd29, 5'd30})));
      is_k28   = k_valid && (enc_byte[4:0] == 5'd28);
   end

   wsg_enc_6b i_enc6 (
      .sym5   (enc_byte[4:0]),
      .is_k28 (is_k28),
      .rd_in  (enc_rd),
      .grp6   (grp6),
      .rd_mid (rd_mid)
   );

   wsg_enc_4b i_enc4 (
      .sym3    (enc_byte[7:5]),
      .sym5    (enc_byte[4:0]),
      .k_valid (k_valid),
      .is_k28  (is_k28),
      .rd_mid  (rd_mid),
      .grp4    (grp4),
      .rd_out  (rd_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= '0;
         rd_q   <= 1'b0;
      end else begin
         code_q <= {grp4, grp6};
         rd_q   <= rd_next;
      end
   end

   assign code_out = code_q;
   assign rd_pos   = rd_q;

   AST_GROUP_WEIGHT: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ($countones(code_out) inside {4, 5, 6})) else $error("bad weight"); // R2

   AST_DATA_DISPARITY: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sync_active
                || (($countones(code_out) == 5) == (rd_pos == $past(rd_pos)))))
      else $error("disparity drift"); // R4

   AST_REQ_STARTS: assert property (@(posedge clk) disable iff (rst)
      (!sync_active && sync_req) |=> sync_active) else $error("request lost"); // R5

   AST_COMMA_FORM: assert property (@(posedge clk) disable iff (rst)
      sync_active |-> ((code_out == COMMA_LEAVES_POS && rd_pos)
                    || (code_out == COMMA_LEAVES_NEG && !rd_pos)))
      else $error("train character malformed"); // R6

   AST_SECOND_REVERSAL: assert property (@(posedge clk) disable iff (rst)
      $rose(sync_active) |=> (sync_active && rd_pos == $past(rd_pos)))
      else $error("second character did not repeat polarity"); // R7

endmodule

// File: tb/test_wsync_gen.sv
module test_wsync_gen;

   localparam logic [9:0] K_POS = 10'h17C;
   localparam logic [9:0] K_NEG = 10'h283;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sync_req = 1'b0;
   logic       ctrl_flag = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic [9:0] code_out;
   logic       rd_pos;
   logic       sync_active;

   int n_cmp = 0;
   int n_bad = 0;
   int act_cnt = 0;

   // bench model
   logic       m_rd = 1'b0, m_act = 1'b0, m_var = 1'b0;
   int         m_pos = 0;
   logic [9:0] e_code;
   logic       e_rd, e_act;

   wsync_gen i_wsync_gen (
      .clk         (clk),
      .rst         (rst),
      .sync_req    (sync_req),
      .ctrl_flag   (ctrl_flag),
      .data_in     (data_in),
      .code_out    (code_out),
      .rd_pos      (rd_pos),
      .sync_active (sync_active)
   );

   always #5 clk = ~clk;

   function automatic logic [5:0] six_neg(input logic [4:0] x);
      logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                             6'b110101, 6'b101001, 6'b011001, 6'b111000,
                             6'b111001, 6'b100101, 6'b010101, 6'b110100,
                             6'b001101, 6'b101100, 6'b011100, 6'b010111,
                             6'b011011, 6'b100011, 6'b010011, 6'b110010,
                             6'b001011, 6'b101010, 6'b011010, 6'b111010,
                             6'b110011, 6'b100110, 6'b010110, 6'b110110,
                             6'b001110, 6'b101110, 6'b011110, 6'b101011};
      return t[x];
   endfunction

   // returns {rd_after, code}
   function automatic logic [10:0] ref_enc(input logic [7:0] b, input logic k, input logic rdp);
      logic [4:0] x = b[4:0];
      logic [2:0] y = b[7:5];
      logic kv, k28, rd1, rd2, a7;
      logic [5:0] s6;
      logic [3:0] s4;
      logic [9:0] c;
      kv  = k && (x == 28 || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30)));
      k28 = kv && x == 28;
      s6  = k28 ? 6'b001111 : six_neg(x);
      if (rdp) begin
         if ($countones(s6) == 4) s6 = ~s6;
         else if (x == 7 && !k28) s6 = ~s6;
      end
      rd1 = ($countones(s6) == 3) ? rdp : ($countones(s6) == 4);
      a7  = kv || (!rd1 && (x == 17 || x == 18 || x == 20)) || (rd1 && (x == 11 || x == 13 || x == 14));
      case (y)
         0: s4 = rd1 ? 4'b0100 : 4'b1011;
         1: s4 = (k28 && !rd1) ? 4'b0110 : 4'b1001;
         2: s4 = (k28 && !rd1) ? 4'b1010 : 4'b0101;
         3: s4 = rd1 ? 4'b0011 : 4'b1100;
         4: s4 = rd1 ? 4'b0010 : 4'b1101;
         5: s4 = (k28 && !rd1) ? 4'b0101 : 4'b1010;
         6: s4 = (k28 && !rd1) ? 4'b1001 : 4'b0110;
         default: s4 = a7 ? (rd1 ? 4'b1000 : 4'b0111) : (rd1 ? 4'b0001 : 4'b1110);
      endcase
      rd2 = ($countones(s4) == 2) ? rd1 : ($countones(s4) == 3);
      for (int n = 0; n < 6; n++) c[n] = s6[5-n];
      for (int n = 0; n < 4; n++) c[6+n] = s4[3-n];
      return {rd2, c};
   endfunction

   // polarity of train character i for a train started at negative disparity (R7)
   function automatic logic pol_a(input int i);
      if (i < 2) return 1'b1;
      if (i < 4) return 1'b0;
      return (i % 2) == 0;
   endfunction

   task automatic model_step(input logic r, input logic c, input logic [7:0] d);
      logic cont, start, p;
      logic [10:0] res;
      cont  = m_act && m_pos != 15;
      start = !cont && r;
      if (cont) m_pos++;
      else if (start) begin m_pos = 0; m_var = m_rd; end
      if (cont || start) begin
         p      = pol_a(m_pos) ^ m_var;
         e_code = p ? K_POS : K_NEG;
         m_rd   = p;
         m_act  = 1'b1;
      end else begin
         res    = ref_enc(d, c, m_rd);
         e_code = res[9:0];
         m_rd   = res[10];
         m_act  = 1'b0;
      end
      e_rd  = m_rd;
      e_act = m_act;
   endtask

   task automatic chk(input string tg, input logic [9:0] act, input logic [9:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic c, input logic [7:0] d, input string tg);
      @(negedge clk);
      sync_req = r; ctrl_flag = c; data_in = d;
      model_step(r, c, d);
      @(posedge clk);
      #1;
      chk(tg, code_out, e_code);
      chk("R4 disparity", {9'd0, rd_pos}, {9'd0, e_rd});
      chk("R11 status", {9'd0, sync_active}, {9'd0, e_act});
      if (sync_active) act_cnt++;
   endtask

   function automatic logic [7:0] pick_k(input int n);
      logic [7:0] ks [4] = '{8'hF7, 8'hFB, 8'hFD, 8'hFE};
      if (n < 8) return {3'(n), 5'd28};
      return ks[n - 8];
   endfunction

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 code", code_out, 10'h000);
      chk("R1 disparity", {9'd0, rd_pos}, 10'd0);
      chk("R1 status", {9'd0, sync_active}, 10'd0);
      rst = 1'b0;
      #1;
      chk("R1 code after release", code_out, 10'h000);

      // plain data
      for (int i = 0; i < 12; i++) cyc(0, 0, 8'(i * 23 + 1), "R2");

      // force negative disparity, then a train of the first variant
      while (m_rd) cyc(0, 0, 8'($urandom), "R2");
      act_cnt = 0;
      cyc(1, 1, 8'hFF, "R5");
      for (int i = 0; i < 15; i++) cyc(1'($urandom), 1'($urandom), 8'($urandom), "R7 R8");
      chk("R11 train length", 10'(act_cnt), 10'd16);
      chk("R9 disparity at end", {9'd0, rd_pos}, 10'd0);
      cyc(0, 0, 8'h03, "R9");
      cyc(0, 0, 8'h04, "R9");

      // reach positive disparity, then a train of the second variant
      for (int g = 0; g < 50 && !m_rd; g++) cyc(0, 0, 8'($urandom), "R2");
      chk("R7 start disparity", {9'd0, rd_pos}, 10'd1);
      cyc(1, 0, 8'h55, "R5");
      for (int i = 0; i < 15; i++) cyc(0, 1'($urandom), 8'($urandom), "R7 R8");
      chk("R9 disparity at end", {9'd0, rd_pos}, 10'd1);
      cyc(0, 0, 8'h21, "R9");

      // request held high: trains back to back
      act_cnt = 0;
      for (int i = 0; i < 48; i++) cyc(1, 1'($urandom), 8'($urandom), "R10");
      chk("R10 no gap", 10'(act_cnt), 10'd48);
      cyc(1, 0, 8'h00, "R10");
      cyc(0, 0, 8'h11, "R10");

      // control characters at both disparities, and invalid ones
      for (int rep = 0; rep < 3; rep++)
         for (int n = 0; n < 12; n++) cyc(0, 1, pick_k(n), "R3");
      cyc(0, 1, 8'h00, "R3");
      cyc(0, 1, 8'hE0, "R3");
      cyc(0, 1, 8'hF6, "R3");

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic r, c;
         logic [7:0] d;
         r = ($urandom % 25) == 0;
         c = ($urandom % 5) == 0;
         d = (c && ($urandom % 2 == 0)) ? pick_k(int'($urandom % 12)) : 8'($urandom);
         cyc(r, c, d, m_act ? "R6" : (c ? "R3" : "R2"));
      end

      summary();
      $finish;
   end

endmodule